// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block takes a 64-bit request word that a core writes to raise a software-generated interrupt. It then decides which cores in a table of core affinities receive it. In targeted mode a core is chosen when its three upper affinity bytes equal the ones in the request and the request's 16-bit target list has the bit set that its lowest affinity byte indexes. In broadcast mode every active core except the requester is chosen, and the target list plays no part.

The dispatcher visits the cores one per clock, in index order, starting at index 0 and stopping below the active-core count. For each chosen core it emits a one-hot pending-set strobe, together with the interrupt number. Chosen cores are struck from a working copy of the target list. In targeted mode the walk finishes as soon as that copy becomes empty. A one-cycle done pulse ends every request. An updated flag is raised with the done pulse when at least one core was signalled; surrounding logic uses it to refresh interrupt state and wake cores.

Top module: `sgi_dispatch`

## Requirements
- R1: Request word layout: target list in bits [15:0], affinity byte 1 in [23:16], interrupt number in [27:24], affinity byte 2 in [39:32], broadcast bit in [40], affinity byte 3 in [55:48]. All other bits are ignored. Each core table entry is 32 bits: {aff3, aff2, aff1, aff0}.
- R2: With the broadcast bit clear, a core is chosen only if its aff3, aff2 and aff1 equal the request's and target-list bit aff0 is set. An aff0 of 16 or more never matches.
- R3: Each chosen core's aff0 bit is cleared from a working target list. In targeted mode the walk ends, before the next core is visited, once that list is zero. Done is high in the (n+1)-th cycle after acceptance, where n is the number of cores visited.
- R4: With the broadcast bit set, every active core except the requester index is chosen, whatever the target list holds.
- R5: Core i, when chosen, gets a pending_set strobe with only bit i high in the (i+1)-th cycle after acceptance. pend_sgi carries the request's interrupt number during the strobe.
- R6: updated is high only in the done cycle, and only if at least one strobe was issued for that request.
- R7: A request is accepted only while req_ready is high (idle). A req_valid seen while busy is ignored and leaves the current walk unchanged.
- R8: Cores at an index at or above core_count are never visited or signalled.
- R9: After reset the block is idle: req_ready high, with pend_set, done and updated low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request word present |
| req_word | input | 64 | Interrupt request word |
| req_core | input | $clog2(NUM_CORES) | Index of the requesting core |
| core_aff | input | 32*NUM_CORES | Affinity table, entry i in bits [32i+31:32i] |
| core_count | input | $clog2(NUM_CORES+1) | Number of active cores |
| req_ready | output | 1 | Dispatcher idle, request will be accepted |
| pend_set | output | NUM_CORES | One-hot pending-set strobe |
| pend_sgi | output | 4 | Interrupt number for the strobe |
| done | output | 1 | One-cycle end-of-request pulse |
| updated | output | 1 | At least one core was signalled (valid with done) |

## Verification
The clock edge that accepts a request counts as edge 0. The strobe for core i is due after edge i+1, and done with updated is due after edge n+1, where n is the number of cores the requirements say get visited. The bench samples on the falling edge and numbers every sample from acceptance. A strobe is checked against the core index its sample number implies, and the done pulse must land on exactly the computed sample. Expected strobe sets, updated values and done positions are worked out by hand from the core table for each vector.

// File: rtl/sgi_dispatch_pkg.sv
package sgi_dispatch_pkg;
  localparam int AFF_W  = 8;
  localparam int TL_W   = 16;
  localparam int SGI_W  = 4;
  localparam int WORD_W = 64;
  localparam int ENT_W  = 4 * AFF_W;

  localparam int TL_LSB   = 0;
  localparam int AFF1_LSB = 16;
  localparam int SGI_LSB  = 24;
  localparam int AFF2_LSB = 32;
  localparam int BC_BIT   = 40;
  localparam int AFF3_LSB = 48;

  typedef struct packed {
    logic [AFF_W-1:0] aff3;
    logic [AFF_W-1:0] aff2;
    logic [AFF_W-1:0] aff1;
    logic             bcast;
    logic [SGI_W-1:0] sgi;
    logic [TL_W-1:0]  tlist;
  } sgi_req_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_WALK = 1'b1} walk_st_e;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_dispatch_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output sgi_req_t          req
);
  logic unused_rsvd;

  always_comb begin
    req.tlist = word[TL_LSB +: TL_W];
    req.aff1  = word[AFF1_LSB +: AFF_W];
    req.sgi   = word[SGI_LSB +: SGI_W];
    req.aff2  = word[AFF2_LSB +: AFF_W];
    req.bcast = word[BC_BIT];
    req.aff3  = word[AFF3_LSB +: AFF_W];
  end

  assign unused_rsvd = ^{word[63:56], word[47:41], word[31:28]};
endmodule

// File: rtl/sgi_core_match.sv
module sgi_core_match
  import sgi_dispatch_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  sgi_req_t         req,
  input  logic [TL_W-1:0]  work_list,
  input  logic             is_requester,
  output logic             sel,
  output logic [TL_W-1:0]  strike
);
  localparam int TL_IDX_W = $clog2(TL_W);

  logic [AFF_W-1:0]    lvl0;
  logic                upper_eq;
  logic                in_list;
  logic [TL_W-1:0]     lvl0_bit;

  always_comb begin
    lvl0     = entry[AFF_W-1:0];
    upper_eq = (entry[ENT_W-1:AFF_W] == {req.aff3, req.aff2, req.aff1});
    if (lvl0 < AFF_W'(TL_W))
      lvl0_bit = TL_W'(1) << lvl0[TL_IDX_W-1:0];
    else
      lvl0_bit = '0;
    in_list = |(work_list & lvl0_bit);
    if (req.bcast) begin
      sel    = !is_requester;
      strike = '0;
    end else begin
      sel    = upper_eq && in_list;
      strike = sel ? lvl0_bit : '0;
    end
  end
endmodule

// File: rtl/sgi_walk_ctrl.sv
module sgi_walk_ctrl
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 8,
  localparam int IDX_W = $clog2(NUM_CORES),
  localparam int CNT_W = $clog2(NUM_CORES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  sgi_req_t             req_in,
  input  logic [IDX_W-1:0]     req_core,
  input  logic [CNT_W-1:0]     core_count,
  input  logic                 core_sel,
  input  logic [TL_W-1:0]      core_strike,
  output sgi_req_t             req_q,
  output logic [TL_W-1:0]      list_q,
  output logic [CNT_W-1:0]     idx_q,
  output logic                 is_requester,
  output logic                 ready,
  output logic [NUM_CORES-1:0] pend_q,
  output logic                 done_q,
  output logic                 upd_q
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(NUM_CORES);

  walk_st_e             st_q, st_n;
  sgi_req_t             req_n;
  logic [TL_W-1:0]      list_n;
  logic [CNT_W-1:0]     idx_n;
  logic [IDX_W-1:0]     rq_q, rq_n;
  logic                 any_q, any_n;
  logic [NUM_CORES-1:0] pend_n;
  logic                 done_n, upd_n;
  logic                 accept, stop, visit;

  assign ready        = (st_q == ST_IDLE);
  assign is_requester = (CNT_W'(rq_q) == idx_q);

  always_comb begin
    accept = ready && req_valid;
    stop   = (idx_q >= core_count) || (idx_q >= MAX_CNT) ||
             (!req_q.bcast && (list_q == '0));
    visit  = (st_q == ST_WALK) && !stop;
    st_n   = st_q;
    req_n  = req_q;
    list_n = list_q;
    idx_n  = idx_q;
    rq_n   = rq_q;
    any_n  = any_q;
    pend_n = '0;
    done_n = 1'b0;
    upd_n  = 1'b0;
    if (accept) begin
      st_n   = ST_WALK;
      req_n  = req_in;
      list_n = req_in.tlist;
      idx_n  = '0;
      rq_n   = req_core;
      any_n  = 1'b0;
    end else if (st_q == ST_WALK) begin
      if (stop) begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
        upd_n  = any_q;
      end else begin
        idx_n = idx_q + 1'b1;
        if (core_sel) begin
          pend_n = NUM_CORES'(1) << idx_q;
          list_n = list_q & ~core_strike;
          any_n  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      done_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      done_q <= done_n;
      upd_q  <= upd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      rq_q   <= '0;
    end else if (accept) begin
      req_q  <= req_n;
      rq_q   <= rq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      list_q <= '0;
      idx_q  <= '0;
      any_q  <= 1'b0;
    end else if (accept || visit) begin
      list_q <= list_n;
      idx_q  <= idx_n;
      any_q  <= any_n;
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 8,
  localparam int IDX_W = $clog2(NUM_CORES),
  localparam int CNT_W = $clog2(NUM_CORES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [63:0]                req_word,
  input  logic [IDX_W-1:0]           req_core,
  input  logic [32*NUM_CORES-1:0]    core_aff,
  input  logic [CNT_W-1:0]           core_count,
  output logic                       req_ready,
  output logic [NUM_CORES-1:0]       pend_set,
  output logic [3:0]                 pend_sgi,
  output logic                       done,
  output logic                       updated
);
  sgi_req_t         req_dec, req_q;
  logic [TL_W-1:0]  list_q, strike;
  logic [CNT_W-1:0] idx_q;
  logic             is_req, sel;
  logic [ENT_W-1:0] table_ent [NUM_CORES];
  logic [ENT_W-1:0] cur_ent;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_tab
    assign table_ent[g] = core_aff[g*ENT_W +: ENT_W];
  end

  assign cur_ent = (idx_q < CNT_W'(NUM_CORES)) ? table_ent[idx_q[IDX_W-1:0]] : '0;

  sgi_req_decode u_dec (
    .word (req_word),
    .req  (req_dec)
  );

  sgi_core_match u_match (
    .entry        (cur_ent),
    .req          (req_q),
    .work_list    (list_q),
    .is_requester (is_req),
    .sel          (sel),
    .strike       (strike)
  );

  sgi_walk_ctrl #(.NUM_CORES(NUM_CORES)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_in       (req_dec),
    .req_core     (req_core),
    .core_count   (core_count),
    .core_sel     (sel),
    .core_strike  (strike),
    .req_q        (req_q),
    .list_q       (list_q),
    .idx_q        (idx_q),
    .is_requester (is_req),
    .ready        (req_ready),
    .pend_q       (pend_set),
    .done_q       (done),
    .upd_q        (updated)
  );

  assign pend_sgi = req_q.sgi;
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NUM_CORES = 8,
  localparam int CNT_W = $clog2(NUM_CORES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [CNT_W-1:0]     core_count,
  input logic [NUM_CORES-1:0] pend_set,
  input logic                 done,
  input logic                 updated
);
  logic                 seen_q;
  logic [NUM_CORES-1:0] in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen_q <= 1'b0;
    else if (req_valid && req_ready) seen_q <= 1'b0;
    else if (|pend_set)             seen_q <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_CORES; i++)
      in_range[i] = (CNT_W'(i) < core_count);
  end

  a_r5_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_set));
  a_r5_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set) |-> !req_ready);
  a_r6_upd_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    updated |-> done);
  a_r6_upd_matches: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (updated == seen_q));
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set & ~in_range) == '0);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .core_count (core_count),
  .pend_set   (pend_set),
  .done       (done),
  .updated    (updated)
);

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
  localparam int NC = 8;

  typedef struct packed {
    logic [63:0] word;
    logic [2:0]  rq;
    logic [7:0]  mask;
    logic        upd;
    logic [3:0]  cyc;
  } vec_t;

  // word: [55:48] aff3, [40] broadcast, [39:32] aff2, [27:24] sgi, [23:16] aff1, [15:0] list
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0500_0002, 3'd0, 8'h02, 1'b1, 4'd3},  // R2 single target core1
    '{64'h0000_0000_0100_0009, 3'd0, 8'h09, 1'b1, 4'd5},  // R3 early stop after core3
    '{64'h0000_0000_0201_0003, 3'd0, 8'h30, 1'b1, 4'd7},  // R2 aff1=1 cores 4,5
    '{64'h0000_0000_0300_0010, 3'd0, 8'h00, 1'b0, 4'd7},  // R2 aff0=4 absent
    '{64'h0000_0000_0402_0001, 3'd0, 8'h00, 1'b0, 4'd7},  // R8 core6 beyond count
    '{64'h0000_0100_0F00_0000, 3'd2, 8'h3B, 1'b1, 4'd7},  // R4 broadcast, req 2
    '{64'h0000_0000_0600_0000, 3'd0, 8'h00, 1'b0, 4'd1},  // R3 empty list
    '{64'h0000_0001_0700_0001, 3'd0, 8'h00, 1'b0, 4'd7},  // R1 aff2 mismatch
    '{64'h0000_0100_0900_FFFF, 3'd0, 8'h3E, 1'b1, 4'd7},  // R4 list ignored
    '{64'h0001_0000_0800_0001, 3'd0, 8'h00, 1'b0, 4'd7}   // R1 aff3 mismatch
  };

  logic          clk, rst_n, req_valid;
  logic [63:0]   req_word;
  logic [2:0]    req_core;
  logic [255:0]  core_aff;
  logic [3:0]    core_count;
  logic          req_ready, done, updated;
  logic [NC-1:0] pend_set;
  logic [3:0]    pend_sgi;

  int total = 0;
  int bad   = 0;
  int cyc_cnt = 0;

  sgi_dispatch #(.NUM_CORES(NC)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .req_core(req_core), .core_aff(core_aff), .core_count(core_count),
    .req_ready(req_ready), .pend_set(pend_set), .pend_sgi(pend_sgi),
    .done(done), .updated(updated)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // run one request; optional poke while busy
  task automatic run(input logic [63:0] w, input logic [2:0] rq,
                     input logic [7:0] emask, input logic eupd, input int ecyc,
                     input bit poke, input string tag);
    logic [7:0] seen = '0;
    logic       upd  = 1'b0;
    int         dcyc = -1;
    int         order_err = 0;
    int         sgi_err = 0;
    @(negedge clk);
    req_word  = w;
    req_core  = rq;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c < 40; c++) begin
      @(negedge clk);
      if (poke && c == 2) begin
        req_word  = 64'h0000_0000_0500_0002;
        req_valid = 1'b1;
      end
      if (poke && c == 3) req_valid = 1'b0;
      if (pend_set != '0) begin
        if (pend_set != (8'h01 << (c - 1))) order_err++;
        if (pend_sgi != w[27:24]) sgi_err++;
        seen |= pend_set;
      end
      if (done) begin
        dcyc = c;
        upd  = updated;
        break;
      end
    end
    chk({tag, " R5 strobe set"}, seen, emask);
    chk({tag, " R6 updated"}, upd, eupd);
    chk({tag, " R3 done cycle"}, dcyc, ecyc);
    chk({tag, " R5 order errors"}, order_err, 0);
    chk({tag, " R5 sgi number errors"}, sgi_err, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_word = '0;
    req_core = '0;
    core_count = 4'd6;
    for (int i = 0; i < 4; i++) core_aff[i*32 +: 32] = 32'(i);
    core_aff[4*32 +: 32] = 32'h0000_0100;
    core_aff[5*32 +: 32] = 32'h0000_0101;
    core_aff[6*32 +: 32] = 32'h0000_0200;
    core_aff[7*32 +: 32] = 32'h0000_0201;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 ready", req_ready, 1);
    chk("R9 pend_set", pend_set, 0);
    chk("R9 done", done, 0);
    chk("R9 updated", updated, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after release", {req_ready, done}, 2'b10);

    for (int v = 0; v < NV; v++)
      run(VECS[v].word, VECS[v].rq, VECS[v].mask, VECS[v].upd,
          int'(VECS[v].cyc), 1'b0, $sformatf("vec%0d", v));

    // R7 request while busy is ignored
    run(64'h0000_0000_0300_0010, 3'd0, 8'h00, 1'b0, 7, 1'b1, "R7 busy poke");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 no walk after ignored req", {pend_set, done}, 0);
      chk("R7 ready stays high", req_ready, 1);
    end

    // R8 single active core, broadcast from it
    core_count = 4'd1;
    run(64'h0000_0100_0200_0000, 3'd0, 8'h00, 1'b0, 2, 1'b0, "R8 count1 bcast");
    // R8 zero active cores
    core_count = 4'd0;
    run(64'h0000_0000_0200_0001, 3'd0, 8'h00, 1'b0, 1, 1'b0, "R8 count0");
    // R4 full table broadcast from the last core
    core_count = 4'd8;
    run(64'h0000_0100_0C00_0000, 3'd7, 8'h7F, 1'b1, 9, 1'b0, "R4 all but 7");
    // R2 core7 reachable with full count
    run(64'h0000_0000_0D02_0002, 3'd0, 8'h80, 1'b1, 9, 1'b0, "R2 core7");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule